// File: doc/BRIEF.md
# Single-Wire Bus Device-Side Slot Decoder

This block sits on the device end of a single open-drain data line that a bus master controls. It watches a line level that has already been synchronized to the clock, and it measures every interval in microseconds from a one-cycle tick. A long low from the master counts as a bus reset. When the line rises again, the block waits briefly and then pulls the line low to signal that it is present.

Every other falling edge starts a time slot. The upper layer chooses the slot type before the edge arrives. In a receive slot the block takes one sample of the line at a fixed offset after the edge. It reports that bit with a strobe one clock wide. In a send slot it either keeps the line low for a fixed time after the edge, which sends a 0, or leaves the line alone, which sends a 1. The master samples the line partway through the slot.

Top module: `owbs_slave`

## Requirements
- R1: After synchronous reset, `pull_low` and `rx_valid` are 0, so the released line reads high.
- R2: A low lasting `RESET_MIN_US` (480) ticks or more is a bus reset. From the rise that ends it, the block waits `PRES_WAIT_US` (30) ticks, then holds `pull_low` at 1 for `PRES_LOW_US` (120) ticks, then releases it.
- R3: A low shorter than `RESET_MIN_US` never produces the presence response.
- R4: In a receive slot (`tx_mode` = 0 at the falling edge), the line is sampled `SAMPLE_US` (30) ticks after the edge. `rx_bit` gets 1 for a high sample and 0 for a low one, and `rx_valid` pulses for exactly one clock, once per slot.
- R5: In a send slot (`tx_mode` = 1) with `tx_bit` = 0, `pull_low` is 1 from the clock after the falling edge until `HOLD0_US` (45) ticks after the edge, then 0.
- R6: In a send slot with `tx_bit` = 1, `pull_low` stays 0 for the whole slot.
- R7: `tx_mode` and `tx_bit` are captured at the falling edge. Changing them during the slot does not change that slot's behaviour.
- R8: A bus reset detected during a slot ends the slot at once, releasing any pull from it, and the presence response of R2 follows.
- R9: A send slot never raises `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle pulse, once per microsecond |
| line_in | input | 1 | Synchronized bus line level |
| tx_mode | input | 1 | 1 = next slot is a send slot, 0 = receive slot |
| tx_bit | input | 1 | Bit to send in the next send slot |
| pull_low | output | 1 | Enable for the open-drain pull-down |
| rx_bit | output | 1 | Last bit received |
| rx_valid | output | 1 | One-clock strobe marking a new `rx_bit` |

## Verification
The hardest case to reach is a bus reset that arrives while the block itself is holding the line low in a send-0 slot. In that case the device's pull and the master's long low overlap, and the slot must be abandoned part way through. The bench starts a send-0 slot and confirms that the device is pulling. The master then keeps the line low well past the reset threshold, and the bench checks that the presence timing that follows is the same as after a plain reset. A 400 µs low provides the near-miss case: it is long but below the threshold, and no presence may follow it.

// File: rtl/owbs_pkg.sv
package owbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SLOT,
        ST_RST_LOW,
        ST_PRES_WAIT,
        ST_PRES_DRIVE,
        ST_RECOVER
    } owbs_state_e;

    typedef struct packed {
        logic is_send;
        logic send_bit;
    } owbs_slot_cfg_t;

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_bits(input int unsigned v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

endpackage

// File: rtl/owbs_edge.sv
module owbs_edge (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic fall_o,
    output logic rise_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= line_i;
    end

    assign fall_o = prev_q & ~line_i;
    assign rise_o = ~prev_q & line_i;

    // a fall must be separated from the next one by a rise (R4)
    p_fall_once_r4: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/owbs_low_timer.sv
module owbs_low_timer #(
    parameter int unsigned CW    = 9,
    parameter int unsigned LIMIT = 480
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic line_i,
    output logic hit_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || line_i)                       cnt_q <= '0;
        else if (tick_i && cnt_q != CW'(LIMIT))  cnt_q <= cnt_q + 1'b1;
    end

    assign hit_o = (cnt_q == CW'(LIMIT));

    // a reset indication needs the line low on the previous clock (R2)
    p_hit_needs_low_r2: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> !$past(line_i));

endmodule

// File: rtl/owbs_phase_timer.sv
module owbs_phase_timer #(
    parameter int unsigned CW   = 9,
    parameter int unsigned MAXV = 480
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)                       cnt_q <= '0;
        else if (tick_i && cnt_q != CW'(MAXV))  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;

    // timing only advances on a microsecond tick (R5)
    p_step_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !tick_i) |=> $stable(cnt_o));

endmodule

// File: rtl/owbs_slave.sv
module owbs_slave #(
    parameter int unsigned RESET_MIN_US = 480,
    parameter int unsigned PRES_WAIT_US = 30,
    parameter int unsigned PRES_LOW_US  = 120,
    parameter int unsigned SAMPLE_US    = 30,
    parameter int unsigned HOLD0_US     = 45
) (
    input  logic clk,
    input  logic rst,
    input  logic us_tick,
    input  logic line_in,
    input  logic tx_mode,
    input  logic tx_bit,
    output logic pull_low,
    output logic rx_bit,
    output logic rx_valid
);
    import owbs_pkg::*;

    localparam int unsigned SLOT_DONE_US = umax(HOLD0_US, SAMPLE_US + 1);
    localparam int unsigned TOP_US = umax(umax(RESET_MIN_US, PRES_LOW_US),
                                          umax(PRES_WAIT_US, SLOT_DONE_US));
    localparam int unsigned CW = cnt_bits(TOP_US);

    owbs_state_e    state_q, state_d;
    owbs_slot_cfg_t cfg_q, cfg_d;
    logic           fall, rise, reset_hit, phase_clr, sample_now;
    logic [CW-1:0]  phase_cnt;
    logic           rx_bit_q, rx_valid_q;

    owbs_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .line_i (line_in),
        .fall_o (fall),
        .rise_o (rise)
    );

    owbs_low_timer #(.CW(CW), .LIMIT(RESET_MIN_US)) u_low (
        .clk    (clk),
        .rst    (rst),
        .tick_i (us_tick),
        .line_i (line_in),
        .hit_o  (reset_hit)
    );

    owbs_phase_timer #(.CW(CW), .MAXV(TOP_US)) u_phase (
        .clk    (clk),
        .rst    (rst),
        .tick_i (us_tick),
        .clr_i  (phase_clr),
        .cnt_o  (phase_cnt)
    );

    always_comb begin
        state_d = state_q;
        cfg_d   = cfg_q;
        if (reset_hit && state_q != ST_RST_LOW) begin
            state_d = ST_RST_LOW;
        end else begin
            unique case (state_q)
                ST_IDLE: if (fall) begin
                    state_d       = ST_SLOT;
                    cfg_d.is_send = tx_mode;
                    cfg_d.send_bit = tx_bit;
                end
                ST_SLOT: if (phase_cnt >= CW'(SLOT_DONE_US) && line_in)
                    state_d = ST_IDLE;
                ST_RST_LOW: if (rise)
                    state_d = ST_PRES_WAIT;
                ST_PRES_WAIT: if (phase_cnt >= CW'(PRES_WAIT_US))
                    state_d = ST_PRES_DRIVE;
                ST_PRES_DRIVE: if (phase_cnt >= CW'(PRES_LOW_US))
                    state_d = ST_RECOVER;
                ST_RECOVER: if (line_in)
                    state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    assign phase_clr  = (state_d != state_q);
    assign sample_now = (state_q == ST_SLOT) && (state_d == ST_SLOT) && !cfg_q.is_send
                        && us_tick && (phase_cnt == CW'(SAMPLE_US - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            cfg_q      <= '0;
            rx_bit_q   <= 1'b0;
            rx_valid_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            cfg_q      <= cfg_d;
            rx_valid_q <= sample_now;
            if (sample_now) rx_bit_q <= line_in;
        end
    end

    assign pull_low = (state_q == ST_PRES_DRIVE)
                   || ((state_q == ST_SLOT) && cfg_q.is_send && !cfg_q.send_bit
                       && (phase_cnt < CW'(HOLD0_US)));
    assign rx_bit   = rx_bit_q;
    assign rx_valid = rx_valid_q;

    p_strobe_single_r4: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    p_no_strobe_send_r9: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> $past(state_q == ST_SLOT && !cfg_q.is_send));

    p_abort_release_r8: assert property (@(posedge clk) disable iff (rst)
        (reset_hit && state_q != ST_RST_LOW) |=> (state_q == ST_RST_LOW && !pull_low));

    p_cfg_held_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SLOT && $past(state_q) == ST_SLOT) |-> $stable(cfg_q));

endmodule

// File: tb/sim_owbs_slave.sv
`timescale 1ns/1ps
module sim_owbs_slave;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic us_tick = 1'b0;
    logic master_low = 1'b0;
    logic tx_mode = 1'b0;
    logic tx_bit = 1'b0;
    logic pull_low, rx_bit, rx_valid;
    logic line;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int strobes = 0;
    int strobe_cyc = 0;
    int fall_cyc = 0;
    logic last_bit = 1'b0;
    logic done = 1'b0;
    int div = 0;

    always #4 clk = ~clk;

    assign line = ~(master_low | pull_low);

    owbs_slave u0 (
        .clk      (clk),
        .rst      (rst),
        .us_tick  (us_tick),
        .line_in  (line),
        .tx_mode  (tx_mode),
        .tx_bit   (tx_bit),
        .pull_low (pull_low),
        .rx_bit   (rx_bit),
        .rx_valid (rx_valid)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        div <= (div == 3) ? 0 : div + 1;
        us_tick <= (div == 3);
        if (rx_valid) begin
            strobes    <= strobes + 1;
            strobe_cyc <= cyc;
            last_bit   <= rx_bit;
        end
    end

    // read slot vectors: bit1 = send slot, bit0 = bit value
    localparam logic [1:0] VEC [0:7] = '{2'b01, 2'b00, 2'b10, 2'b11,
                                         2'b00, 2'b10, 2'b01, 2'b11};

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_us(input int n);
        repeat (4 * n) @(negedge clk);
    endtask

    task automatic do_write(input logic b);
        int s0;
        int d;
        tx_mode = 1'b0;
        s0 = strobes;
        master_low = 1'b1;
        fall_cyc = cyc;
        wait_us(b ? 5 : 70);
        master_low = 1'b0;
        wait_us(b ? 90 : 25);
        chk(strobes == s0 + 1, "R4 strobe count", strobes - s0, 1);
        chk(last_bit == b, "R4 bit", int'(last_bit), int'(b));
        d = strobe_cyc - fall_cyc;
        chk(d >= 116 && d <= 128, "R4 sample time", d, 120);
    endtask

    task automatic do_read(input logic b);
        int s0;
        tx_mode = 1'b1;
        tx_bit = b;
        s0 = strobes;
        master_low = 1'b1;
        wait_us(2);
        master_low = 1'b0;
        wait_us(13);
        chk(line == b, b ? "R6 line at 15us" : "R5 line at 15us", int'(line), int'(b));
        wait_us(25);
        chk(pull_low == !b, b ? "R6 pull at 40us" : "R5 pull at 40us", int'(pull_low), int'(!b));
        wait_us(10);
        chk(pull_low == 1'b0, "R5 release at 50us", int'(pull_low), 0);
        wait_us(45);
        chk(strobes == s0, "R9 no strobe", strobes - s0, 0);
    endtask

    task automatic presence_checks(input logic expect_pres, input string req);
        wait_us(20);
        chk(pull_low == 1'b0, {req, " gap"}, int'(pull_low), 0);
        wait_us(20);
        chk(pull_low == expect_pres, {req, " at 40us"}, int'(pull_low), int'(expect_pres));
        wait_us(100);
        chk(pull_low == expect_pres, {req, " at 140us"}, int'(pull_low), int'(expect_pres));
        wait_us(20);
        chk(pull_low == 1'b0, {req, " end"}, int'(pull_low), 0);
        wait_us(10);
    endtask

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(pull_low == 1'b0, "R1 pull", int'(pull_low), 0);
        chk(rx_valid == 1'b0, "R1 strobe", int'(rx_valid), 0);
        chk(line == 1'b1, "R1 line", int'(line), 1);
        wait_us(5);

        // R2: plain bus reset then presence
        master_low = 1'b1;
        wait_us(500);
        master_low = 1'b0;
        presence_checks(1'b1, "R2");

        for (int i = 0; i < 8; i++) begin
            if (VEC[i][1]) do_read(VEC[i][0]);
            else           do_write(VEC[i][0]);
            wait_us(3);
        end

        // R3: long low below threshold gives no presence
        tx_mode = 1'b0;
        master_low = 1'b1;
        wait_us(400);
        master_low = 1'b0;
        presence_checks(1'b0, "R3");

        // R7: inputs changed mid-slot are ignored
        begin
            int s0;
            s0 = strobes;
            tx_mode = 1'b1;
            tx_bit = 1'b0;
            master_low = 1'b1;
            wait_us(2);
            master_low = 1'b0;
            wait_us(3);
            tx_mode = 1'b0;
            tx_bit = 1'b1;
            wait_us(10);
            chk(line == 1'b0, "R7 line held", int'(line), 0);
            wait_us(60);
            chk(strobes == s0, "R7 no strobe", strobes - s0, 0);
            wait_us(20);
        end

        // R8: reset arriving during a send-0 slot
        tx_mode = 1'b1;
        tx_bit = 1'b0;
        master_low = 1'b1;
        wait_us(20);
        chk(pull_low == 1'b1, "R8 slot pulling", int'(pull_low), 1);
        wait_us(480);
        chk(pull_low == 1'b0, "R8 abort", int'(pull_low), 0);
        master_low = 1'b0;
        presence_checks(1'b1, "R8");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule